// File: doc/BRIEF.md
# Shift-register instruction executor

This block is one sequencer core of a small programmable I/O engine. It fetches a 16-bit instruction each clock from a 32-word program store and executes it in that same clock. The instruction set is SET, IN, OUT, MOV and JMP. The core holds two scratch registers (X and Y), an input shift register and an output shift register. Each shift register has a 6-bit counter that records how many bits have moved through it.

The program store is filled through a write port. The program runs while `run` is high, and every architectural register and counter is brought out to the ports so a surrounding bench or host can observe it. The counters obey precise rules:

- A MOV into a shift register zeroes that register's counter.
- An OUT aimed at the input shift register loads its counter with the OUT bit count.
- The output counter still advances on every OUT.

Top module: `pio_seq_core`

## Requirements
- R1: After reset, pc, X, Y, the input shift register and the output shift register are 0, `isr_cnt` is 0 and `osr_cnt` is 32.
- R2: Bits [15:13] select the operation: 000 JMP, 010 IN, 011 OUT, 101 MOV, 111 SET. Bits [12:8] have no effect. One instruction completes per rising edge while `run` is 1. While `run` is 0, pc and all registers hold their values.
- R3: SET with target [7:5] = 001 writes X, and with 010 writes Y. The value is [4:0] zero-extended. Any other target changes nothing.
- R4: IN takes bits from a source chosen by [7:5]: 001 X, 010 Y, 110 ISR, 111 OSR, other codes read 0. The count is [4:0], with 0 meaning 32, and `isr_cnt` gains the count, saturating at 32.
  - With `shr`=0, the input shift register moves left and the new bits enter at the LSB end.
  - With `shr`=1, it moves right and the new bits enter at the MSB end.
- R5: OUT shifts the count's bits out of the output shift register and adds the count to `osr_cnt`, saturating at 32.
  - With `shr`=1, it takes the bits from the LSB end and shifts right.
  - With `shr`=0, it takes them from the MSB end and shifts left.
  - Target [7:5] = 001 loads X and 010 loads Y, with the bits zero-extended. 000 and 011 discard the bits.
- R6: OUT with target 110 loads the input shift register with the shifted-out bits and sets `isr_cnt` to the count. `osr_cnt` still advances.
- R7: MOV copies from source [2:0] to destination [7:5]. Both fields use the IN codes, and the pin source (000) reads 0.
- R8: MOV into 110 (ISR) sets `isr_cnt` to 0, and MOV into 111 (OSR) sets `osr_cnt` to 0. The other counter is unchanged.
- R9: MOV operation [4:3]: 00 plain copy, 01 bitwise inversion, 10 bit reversal, 11 plain copy.
- R10: JMP loads pc with [4:0] when its condition [7:5] holds. Otherwise pc increments. The conditions are:
  - 000 always.
  - 001 X==0.
  - 010 X!=0, with X decremented either way.
  - 011 Y==0.
  - 100 Y!=0, with Y decremented either way.
  - 101 X!=Y.
  - 110 never.
  - 111 `osr_cnt` < 32.
- R11: Other than a taken JMP, pc advances by one and wraps from 31 to 0.
- R12: A word written through `imem_we`/`imem_waddr`/`imem_wdata` is the one executed when pc reaches that address. Reset leaves the program store untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execute one instruction per clock when high |
| shr | input | 1 | Shift direction for IN and OUT: 1 right, 0 left |
| imem_we | input | 1 | Program store write enable |
| imem_waddr | input | 5 | Program store write address |
| imem_wdata | input | 16 | Program store write data |
| pc | output | 5 | Program counter |
| x | output | 32 | Scratch register X |
| y | output | 32 | Scratch register Y |
| isr | output | 32 | Input shift register |
| osr | output | 32 | Output shift register |
| isr_cnt | output | 6 | Input shift counter |
| osr_cnt | output | 6 | Output shift counter |

## Verification
Every instruction's effect appears on the register and counter ports one rising edge after the cycle in which pc addressed it. A sequence of k instructions is therefore complete after exactly k edges with `run` high. The bench raises `run` at a falling edge and drops it again after k falling edges, so exactly k edges execute. It then reads the ports while the core is paused, and any further edge before the next check is harmless because state holds with `run` low. The corner cases each have their own check: a count of 0 meaning 32, counter saturation, a counter cleared by MOV and then advanced by OUT, a decrementing loop branch, and pc wrap.

// File: rtl/pio_seq_core.sv
module pio_seq_core #(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter int IW = 16,
  localparam int CW = $clog2(DW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          shr,
  input  logic          imem_we,
  input  logic [AW-1:0] imem_waddr,
  input  logic [IW-1:0] imem_wdata,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] x,
  output logic [DW-1:0] y,
  output logic [DW-1:0] isr,
  output logic [DW-1:0] osr,
  output logic [CW-1:0] isr_cnt,
  output logic [CW-1:0] osr_cnt
);
  localparam int DEPTH = 1 << AW;
  localparam logic [CW-1:0] FULL = CW'(DW);

  logic [IW-1:0] mem [DEPTH];
  logic [IW-1:0] ins;
  logic [2:0] opc, fld, ssel;
  logic [1:0] mop;
  logic [4:0] cnt5;
  logic [CW-1:0] nbits;

  always_ff @(posedge clk)
    if (imem_we) mem[imem_waddr] <= imem_wdata;

  assign ins   = mem[pc];
  assign opc   = ins[15:13];
  assign fld   = ins[7:5];
  assign mop   = ins[4:3];
  assign ssel  = ins[2:0];
  assign cnt5  = ins[4:0];
  assign nbits = (cnt5 == 5'd0) ? FULL : CW'(cnt5);

  function automatic logic [DW-1:0] pick(input logic [2:0] s, input logic [DW-1:0] a,
                                         input logic [DW-1:0] b, input logic [DW-1:0] c,
                                         input logic [DW-1:0] d);
    case (s)
      3'b001:  return a;
      3'b010:  return b;
      3'b110:  return c;
      3'b111:  return d;
      default: return '0;
    endcase
  endfunction

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s >= {1'b0, FULL}) ? FULL : s[CW-1:0];
  endfunction

  logic [DW-1:0]   in_src, mv_src, mv_rev, mv_val, mask;
  logic [2*DW-1:0] ones_sh, in_l, in_r, out_l, out_r;
  logic [DW-1:0]   in_dat, isr_in, out_dat, osr_out;

  assign in_src  = pick(fld, x, y, isr, osr);
  assign mv_src  = pick(ssel, x, y, isr, osr);
  assign ones_sh = {{DW{1'b0}}, {DW{1'b1}}} << nbits;
  assign mask    = ~ones_sh[DW-1:0];
  assign in_dat  = in_src & mask;
  assign in_l    = {{DW{1'b0}}, isr} << nbits;
  assign in_r    = {in_dat, isr} >> nbits;
  assign isr_in  = shr ? in_r[DW-1:0] : (in_l[DW-1:0] | in_dat);
  assign out_l   = {{DW{1'b0}}, osr} << nbits;
  assign out_r   = {{DW{1'b0}}, osr} >> nbits;
  assign out_dat = shr ? (osr & mask) : out_l[2*DW-1:DW];
  assign osr_out = shr ? out_r[DW-1:0] : out_l[DW-1:0];

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign mv_rev[i] = mv_src[DW-1-i];
  end

  always_comb
    case (mop)
      2'b01:   mv_val = ~mv_src;
      2'b10:   mv_val = mv_rev;
      default: mv_val = mv_src;
    endcase

  logic take;
  always_comb
    case (fld)
      3'b000:  take = 1'b1;
      3'b001:  take = (x == '0);
      3'b010:  take = (x != '0);
      3'b011:  take = (y == '0);
      3'b100:  take = (y != '0);
      3'b101:  take = (x != y);
      3'b110:  take = 1'b0;
      default: take = (osr_cnt < FULL);
    endcase

  logic [AW-1:0] pc_inc;
  assign pc_inc = pc + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= '0;
      x       <= '0;
      y       <= '0;
      isr     <= '0;
      osr     <= '0;
      isr_cnt <= '0;
      osr_cnt <= FULL;
    end else if (run) begin
      pc <= pc_inc;
      case (opc)
        3'b000: begin
          if (take) pc <= ins[AW-1:0];
          if (fld == 3'b010) x <= x - DW'(1);
          if (fld == 3'b100) y <= y - DW'(1);
        end
        3'b010: begin
          isr     <= isr_in;
          isr_cnt <= sat_add(isr_cnt, nbits);
        end
        3'b011: begin
          osr     <= osr_out;
          osr_cnt <= sat_add(osr_cnt, nbits);
          case (fld)
            3'b001: x <= out_dat;
            3'b010: y <= out_dat;
            3'b110: begin
              isr     <= out_dat;
              isr_cnt <= nbits;
            end
            default: ;
          endcase
        end
        3'b101:
          case (fld)
            3'b001: x <= mv_val;
            3'b010: y <= mv_val;
            3'b110: begin
              isr     <= mv_val;
              isr_cnt <= '0;
            end
            3'b111: begin
              osr     <= mv_val;
              osr_cnt <= '0;
            end
            default: ;
          endcase
        3'b111:
          case (fld)
            3'b001: x <= DW'(cnt5);
            3'b010: y <= DW'(cnt5);
            default: ;
          endcase
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pio_seq_core_chk.sv
module pio_seq_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [15:0] ins,
  input logic [4:0]  pc,
  input logic [31:0] x,
  input logic [31:0] y,
  input logic [5:0]  isr_cnt,
  input logic [5:0]  osr_cnt
);
  // R8
  mov_isr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && ins[15:13] == 3'b101 && ins[7:5] == 3'b110 |=> isr_cnt == 6'd0);

  // R8
  mov_osr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && ins[15:13] == 3'b101 && ins[7:5] == 3'b111 |=> osr_cnt == 6'd0);

  // R6
  out_isr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && ins[15:13] == 3'b011 && ins[7:5] == 3'b110 |=>
      isr_cnt == (($past(ins[4:0]) == 5'd0) ? 6'd32 : {1'b0, $past(ins[4:0])}));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_cnt <= 6'd32 && osr_cnt <= 6'd32);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc) && $stable(x) && $stable(y) && $stable(isr_cnt) && $stable(osr_cnt));

  // R11
  pc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && ins[15:13] != 3'b000 && pc == 5'd31 |=> pc == 5'd0);
endmodule

bind pio_seq_core pio_seq_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .ins(ins), .pc(pc),
  .x(x), .y(y), .isr_cnt(isr_cnt), .osr_cnt(osr_cnt)
);

// File: tb/pio_seq_core_test.sv
module pio_seq_core_test;
  logic clk = 0, rst_n = 0, run = 0, shr = 0, imem_we = 0;
  logic [4:0] imem_waddr = '0;
  logic [15:0] imem_wdata = '0;
  logic [4:0] pc;
  logic [31:0] x, y, isr, osr;
  logic [5:0] isr_cnt, osr_cnt;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pio_seq_core uut (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: got %h want %h", req, what, act, exp);
    end
  endtask

  task automatic ld(int a, logic [15:0] w);
    @(negedge clk);
    imem_we = 1; imem_waddr = 5'(a); imem_wdata = w;
    @(negedge clk);
    imem_we = 0;
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 0; run = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step(int k);
    @(negedge clk);
    run = 1;
    repeat (k) @(negedge clk);
    run = 0;
  endtask

  task automatic t_reset();
    restart();
    chk("R1", "pc", 32'(pc), 0);
    chk("R1", "x", x, 0);
    chk("R1", "isr", isr, 0);
    chk("R1", "isr_cnt", 32'(isr_cnt), 0);
    chk("R1", "osr_cnt", 32'(osr_cnt), 32);
  endtask

  task automatic t_mov_isr();
    shr = 0;
    ld(0, 16'hE023); ld(1, 16'h4022); ld(2, 16'hA0C3); ld(3, 16'h0000);
    restart();
    step(2);
    chk("R4", "isr after in", isr, 3);
    chk("R4", "isr_cnt after in", 32'(isr_cnt), 2);
    step(1);
    chk("R8", "isr after mov", isr, 0);
    chk("R8", "isr_cnt after mov", 32'(isr_cnt), 0);
    chk("R8", "osr_cnt untouched", 32'(osr_cnt), 32);
    chk("R3", "x", x, 3);
  endtask

  task automatic t_mov_osr();
    shr = 1;
    ld(0, 16'hE023); ld(1, 16'hA0E1); ld(2, 16'h6022);
    restart();
    step(2);
    chk("R8", "osr", osr, 3);
    chk("R8", "osr_cnt", 32'(osr_cnt), 0);
    chk("R7", "pc", 32'(pc), 2);
    step(1);
    chk("R5", "x from out", x, 3);
    chk("R5", "osr shifted", osr, 0);
    chk("R5", "osr_cnt", 32'(osr_cnt), 2);
  endtask

  task automatic t_out_isr();
    shr = 1;
    ld(0, 16'hE023); ld(1, 16'hA0E1); ld(2, 16'h60C2);
    restart();
    step(3);
    chk("R6", "isr", isr, 3);
    chk("R6", "isr_cnt", 32'(isr_cnt), 2);
    chk("R6", "osr_cnt", 32'(osr_cnt), 2);
    chk("R6", "osr", osr, 0);
  endtask

  task automatic t_out_left();
    shr = 0;
    ld(0, 16'hE03F); ld(1, 16'hA0E9); ld(2, 16'h6044);
    restart();
    step(3);
    chk("R9", "x", x, 32'h1F);
    chk("R5", "y msb nibble", y, 32'hF);
    chk("R5", "osr left", osr, 32'hFFFFFE00);
    chk("R5", "osr_cnt", 32'(osr_cnt), 4);
  endtask

  task automatic t_in_right();
    shr = 1;
    ld(0, 16'hE025); ld(1, 16'h4023); ld(2, 16'h4060);
    restart();
    step(2);
    chk("R4", "isr right", isr, 32'hA0000000);
    step(1);
    chk("R4", "isr after 32 nulls", isr, 0);
    chk("R4", "isr_cnt saturates", 32'(isr_cnt), 32);
  endtask

  task automatic t_reverse();
    ld(0, 16'hE041); ld(1, 16'hA032);
    restart();
    step(2);
    chk("R9", "reversed x", x, 32'h80000000);
    chk("R7", "y source", y, 1);
  endtask

  task automatic t_jmp();
    ld(0, 16'hE022); ld(1, 16'h0041); ld(2, 16'h0020); ld(3, 16'h0005);
    ld(4, 16'hE04F); ld(5, 16'hE047);
    restart();
    step(7);
    chk("R10", "x after loop", x, 32'hFFFFFFFF);
    chk("R10", "y", y, 7);
    chk("R10", "pc", 32'(pc), 6);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 32; i++) ld(i, 16'hFF40 | 16'(i));
    restart();
    step(32);
    chk("R11", "pc wrapped", 32'(pc), 0);
    chk("R2", "y with delay bits", y, 31);
    step(1);
    chk("R12", "y", y, 0);
    chk("R11", "pc", 32'(pc), 1);
  endtask

  task automatic t_hold();
    ld(0, 16'hE0C5); ld(1, 16'hE049);
    restart();
    step(1);
    chk("R3", "isr unchanged by set", isr, 0);
    ld(1, 16'hE04C);
    repeat (3) @(negedge clk);
    chk("R2", "pc held", 32'(pc), 1);
    chk("R2", "y held", y, 0);
    step(1);
    chk("R12", "rewritten word", y, 12);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: got timeout want completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_mov_isr();
    t_mov_osr();
    t_out_isr();
    t_out_left();
    t_in_right();
    t_reverse();
    t_jmp();
    t_wrap();
    t_hold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule